// File: doc/BRIEF.md
# Serial Receive Register Front-End

This block connects a serial receiver's byte output to a small byte-wide control/status register bus. The receiver offers a data byte and an error flag with a valid/acknowledge handshake. The block accepts an offered byte whenever its 16-entry receive queue has room, and stores the error flag next to the byte. Software then drains the queue through the register bus.

Three registers are visible to software:
- a read/write baud divisor register, whose stored value drives the receiver's divisor input at all times;
- a read-only status register, which shows whether data is waiting and the error flag of the oldest entry;
- a data register. Reading it returns the oldest byte and removes that entry from the queue as a side effect of the read strobe.

Bus reads are registered, so read data appears one cycle after the strobe. The serial line logic and interrupt generation live elsewhere.

Top module: `uart_rx_csr`

## Requirements
- R1: After a synchronous active-low reset: `phy_div` equals parameter `DIV_RST`, `phy_ack` is 1, the queue is empty and `csr_rdata` is 0.
- R2: The divisor register sits at offset 0 and holds `DIV_W` bits. A write there is stored at the strobe's clock edge, so `phy_div` shows `csr_wdata[DIV_W-1:0]` from the next cycle on. A read returns the stored value zero-extended to 8 bits.
- R3: `phy_ack` is high exactly when the queue holds fewer than `FIFO_DEPTH` (16) entries. At every edge where `phy_valid` and `phy_ack` are both high, `phy_byte` and `phy_err` are appended. A byte offered while `phy_ack` is low is not stored.
- R4: The status register sits at offset 3 and reads as follows. Bit 0 is 1 when the queue is not empty. Bit 4 is the error flag of the oldest entry. Bits 1, 2, 3, 5, 6 and 7 always read 0.
- R5: The data register sits at offset 4. A read while the queue is not empty returns the oldest byte and removes that entry. Bytes come out in arrival order.
- R6: A read of offset 4 while the queue is empty does not change the queue. It returns the byte most recently removed, or 0 if nothing has been removed since reset. While the queue is empty, status bit 4 shows that same entry's error flag.
- R7: Writes to offsets 3, 4 and to every unmapped offset (1, 2, 5 to 15) change nothing. Reads of unmapped offsets return 0.
- R8: `csr_rdata` carries the addressed value in the cycle after a cycle with `csr_rd` high, and is 0 in every other cycle.
- R9: A read of offset 4 and an accepted byte at the same edge both take effect. The read returns the old oldest entry and the entry count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 4 | Register offset |
| csr_rd | input | 1 | Read strobe, one cycle per access |
| csr_wr | input | 1 | Write strobe, one cycle per access |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Registered read data |
| phy_valid | input | 1 | Receiver offers a byte |
| phy_byte | input | 8 | Offered byte |
| phy_err | input | 1 | Error flag of the offered byte |
| phy_ack | output | 1 | Queue has room; the offered byte is taken at this edge |
| phy_div | output | DIV_W | Divisor value driven to the receiver |

## Verification
The two functions that can collide are the receiver appending a byte and a bus read of the data register removing one, both at the same edge. The bench provokes this in two ways. A directed stretch holds `phy_valid` high while reading offset 4 on every cycle, starting from a partly filled queue. A long random stretch then mixes offers, reads and writes, including offers against a full queue. A behavioural queue model in the bench predicts `phy_ack`, `phy_div` and `csr_rdata` on every cycle. A collision is judged correct when the read returns the old oldest byte and the following status and acknowledge values match an unchanged entry count.

// File: rtl/uart_rx_csr_pkg.sv
// Package: offsets and entry layout shared by the receive register front-end.
// Assumes an 8-bit register bus with a 4-bit offset.
package uart_rx_csr_pkg;
    localparam int unsigned BUS_AW = 4;
    localparam int unsigned BUS_DW = 8;

    localparam logic [BUS_AW-1:0] OFS_DIV  = 4'd0;
    localparam logic [BUS_AW-1:0] OFS_STAT = 4'd3;
    localparam logic [BUS_AW-1:0] OFS_DATA = 4'd4;

    localparam int unsigned STAT_NE_BIT  = 0;
    localparam int unsigned STAT_ERR_BIT = 4;

    // Queue entry: error flag in the top bit, byte below it.
    typedef struct packed {
        logic              err;
        logic [BUS_DW-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rx_sync_fifo.sv
// Synchronous receive queue with an occupancy counter.
// Pushes are refused when full. Pops are ignored when empty.
// When empty, the head output shows the most recently popped entry
// (zero after reset), so that an empty read returns a stale value.
module rx_sync_fifo
    import uart_rx_csr_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_req,
    input  rx_entry_t push_entry,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic      not_empty,
    output logic      not_full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rx_entry_t        mem [DEPTH];
    rx_entry_t        last_pop;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             empty;
    logic             push_ok;
    logic             pop_ok;

    assign full      = (count == FULL_CNT);
    assign empty     = (count == '0);
    assign push_ok   = push_req & ~full;
    assign pop_ok    = pop_req & ~empty;
    assign not_empty = ~empty;
    assign not_full  = ~full;
    assign head      = empty ? last_pop : mem[rd_ptr];

    // Storage write for an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_entry;
        end
    end

    // Pointer, occupancy and last-popped entry update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            last_pop <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr   <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
                last_pop <= mem[rd_ptr];
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> (full && $stable(rd_ptr))); // R3
    AST_EMPTY_POP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req) |=> (empty && $stable(last_pop) && $stable(rd_ptr))); // R6
    AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !full && !empty) |=> $stable(count)); // R9
endmodule

// File: rtl/div_field_reg.sv
// Read/write divisor storage. It loads at the edge of a write strobe
// and drives its value continuously. Assumes 1 <= W <= 8.
module div_field_reg #(
    parameter int unsigned      W   = 7,
    parameter logic [W-1:0]     RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Storage with synchronous reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

    AST_DIV_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata))); // R2
    AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R7
endmodule

// File: rtl/csr_decode.sv
// Offset decode, write and pop strobes, and the registered read mux.
// Assumes single-cycle read and write strobes. Read data is zero in
// cycles that do not follow a read.
module csr_decode
    import uart_rx_csr_pkg::*;
#(
    parameter int unsigned DIV_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DIV_W-1:0]  div_q,
    input  rx_entry_t         head,
    input  logic              not_empty,
    output logic              div_wr,
    output logic              pop_req,
    output logic [BUS_DW-1:0] rdata
);
    logic [BUS_DW-1:0] div_ext;
    logic [BUS_DW-1:0] rd_val;
    logic              mapped;

    generate
        if (DIV_W < BUS_DW) begin : g_pad
            assign div_ext = {{(BUS_DW - DIV_W){1'b0}}, div_q};
        end else begin : g_full
            assign div_ext = div_q;
        end
    endgenerate

    assign div_wr  = wr && (addr == OFS_DIV);
    assign pop_req = rd && (addr == OFS_DATA);
    assign mapped  = (addr == OFS_DIV) || (addr == OFS_STAT) || (addr == OFS_DATA);

    // Select the value for the addressed register.
    always_comb begin
        rd_val = '0;
        case (addr)
            OFS_DIV:  rd_val = div_ext;
            OFS_STAT: begin
                rd_val[STAT_NE_BIT]  = not_empty;
                rd_val[STAT_ERR_BIT] = head.err;
            end
            OFS_DATA: rd_val = head.data;
            default:  rd_val = '0;
        endcase
    end

    // Register read data for one cycle after a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd ? rd_val : '0;
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mapped) |=> (rdata == '0)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0)); // R8
    AST_STAT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == OFS_STAT) |=> (rdata[7:5] == 3'b000 && rdata[3:1] == 3'b000)); // R4
endmodule

// File: rtl/uart_rx_csr.sv
// Top of the receive register front-end. It joins the divisor storage,
// the receive queue and the register decode. The receiver is
// acknowledged whenever the queue has room. Reads of the data offset pop.
module uart_rx_csr
    import uart_rx_csr_pkg::*;
#(
    parameter int unsigned      DIV_W      = 7,
    parameter logic [DIV_W-1:0] DIV_RST    = 7'h45,
    parameter int unsigned      FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        csr_addr,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [7:0]        csr_wdata,
    output logic [7:0]        csr_rdata,
    input  logic              phy_valid,
    input  logic [7:0]        phy_byte,
    input  logic              phy_err,
    output logic              phy_ack,
    output logic [DIV_W-1:0]  phy_div
);
    rx_entry_t in_entry;
    rx_entry_t head;
    logic      not_empty;
    logic      not_full;
    logic      div_wr;
    logic      pop_req;

    assign in_entry = '{err: phy_err, data: phy_byte};
    assign phy_ack  = not_full;

    div_field_reg #(.W(DIV_W), .RST(DIV_RST)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (div_wr),
        .wdata (csr_wdata[DIV_W-1:0]),
        .q     (phy_div)
    );

    rx_sync_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (phy_valid),
        .push_entry (in_entry),
        .pop_req    (pop_req),
        .head       (head),
        .not_empty  (not_empty),
        .not_full   (not_full)
    );

    csr_decode #(.DIV_W(DIV_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (csr_addr),
        .rd        (csr_rd),
        .wr        (csr_wr),
        .div_q     (phy_div),
        .head      (head),
        .not_empty (not_empty),
        .div_wr    (div_wr),
        .pop_req   (pop_req),
        .rdata     (csr_rdata)
    );

    AST_ACK_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && not_empty && !phy_valid) |=> phy_ack); // R3
endmodule

// File: tb/uart_rx_csr_tb.sv
// Bench: a behavioural queue model, stepped once per clock, predicts
// phy_ack, phy_div and csr_rdata. These are compared at each falling edge.
module uart_rx_csr_tb;
    localparam int unsigned    DIV_W   = 7;
    localparam logic [6:0]     DIV_RST = 7'h45;
    localparam int             DEPTH   = 16;
    localparam int             MASK    = (1 << DIV_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] csr_addr = '0;
    logic       csr_rd = 1'b0;
    logic       csr_wr = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic       phy_valid = 1'b0;
    logic [7:0] phy_byte = '0;
    logic       phy_err = 1'b0;
    logic       phy_ack;
    logic [6:0] phy_div;

    int    n_checks = 0;
    int    n_fail = 0;
    int    q[$];
    int    last_pop = 0;
    int    m_div = int'(DIV_RST);
    int    exp_rdata = 0;
    string rd_tag = "R8";

    always #2 clk = ~clk;

    uart_rx_csr #(.DIV_W(DIV_W), .DIV_RST(DIV_RST), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .phy_valid(phy_valid), .phy_byte(phy_byte), .phy_err(phy_err),
        .phy_ack(phy_ack), .phy_div(phy_div)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the outputs, apply the inputs for the next edge, then step the model.
    task automatic cycle(bit rd, bit wr, int addr, int wdata, bit vld, int dbyte, bit derr);
        int  head;
        bit  empty;
        bit  full;
        bit  popped;
        @(negedge clk);
        check("R3 ack", int'(phy_ack), (q.size() < DEPTH) ? 1 : 0);
        check("R2 div", int'(phy_div), m_div);
        check({rd_tag, " rdata"}, int'(csr_rdata), exp_rdata);
        csr_rd = rd; csr_wr = wr; csr_addr = addr[3:0]; csr_wdata = wdata[7:0];
        phy_valid = vld; phy_byte = dbyte[7:0]; phy_err = derr;
        empty  = (q.size() == 0);
        full   = (q.size() == DEPTH);
        head   = empty ? last_pop : q[0];
        popped = 1'b0;
        exp_rdata = 0;
        rd_tag = "R8";
        if (rd) begin
            case (addr)
                0: begin exp_rdata = m_div; rd_tag = "R2"; end
                3: begin exp_rdata = ((head >> 8) << 4) | (empty ? 0 : 1); rd_tag = "R4"; end
                4: begin
                    exp_rdata = head & 8'hFF;
                    rd_tag = empty ? "R6" : ((vld && !full) ? "R9" : "R5");
                    if (!empty) begin
                        last_pop = q.pop_front();
                        popped = 1'b1;
                    end
                end
                default: begin exp_rdata = 0; rd_tag = "R7"; end
            endcase
        end
        if (vld && !full) q.push_back({derr, dbyte[7:0]});
        if (wr && addr == 0) m_div = wdata & MASK;
        if (popped) rd_tag = rd_tag;
    endtask

    task automatic rd_reg(int addr);
        cycle(1'b1, 1'b0, addr, 0, 1'b0, 0, 1'b0);
    endtask

    task automatic wr_reg(int addr, int val);
        cycle(1'b0, 1'b1, addr, val, 1'b0, 0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values before the first active edge.
        check("R1 ack", int'(phy_ack), 1);
        check("R1 div", int'(phy_div), int'(DIV_RST));
        check("R1 rdata", int'(csr_rdata), 0);

        // R2: divisor write, truncation and read-back.
        rd_reg(0);
        wr_reg(0, 8'hFF);
        rd_reg(0);
        wr_reg(0, 8'h12);
        rd_reg(0);
        cycle(1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0);

        // R6/R4: empty queue reads after reset.
        rd_reg(4);
        rd_reg(3);
        cycle(1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0);

        // R3: overfill the queue with no reads.
        for (int i = 0; i < 20; i++) begin
            cycle(1'b0, 1'b0, 0, 0, 1'b1, 8'hA0 + i, i[0]);
        end
        cycle(1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0);

        // R7: ignored writes and unmapped reads.
        wr_reg(3, 8'hFF);
        wr_reg(4, 8'hFF);
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 3 && a != 4) begin
                wr_reg(a, 8'hFF);
                rd_reg(a);
            end
        end
        rd_reg(0);

        // R4/R5/R6: drain with status reads, past empty.
        for (int i = 0; i < 18; i++) begin
            rd_reg(3);
            rd_reg(4);
        end
        rd_reg(3);

        // R9: simultaneous push and pop.
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 0, 0, 1'b1, 8'h30 + i, 1'b1);
        for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0, 4, 0, 1'b1, 8'h50 + i, i[1]);
        rd_reg(3);

        // Mixed random traffic.
        for (int i = 0; i < 3000; i++) begin
            int  sel;
            int  a;
            bit  r;
            bit  w;
            sel = $urandom_range(0, 7);
            a = (sel < 3) ? 4 : (sel < 5) ? 3 : (sel == 5) ? 0 : $urandom_range(0, 15);
            r = ($urandom_range(0, 2) != 0);
            w = ($urandom_range(0, 5) == 0);
            cycle(r, w, a, $urandom_range(0, 255), ($urandom_range(0, 1) == 1),
                  $urandom_range(0, 255), ($urandom_range(0, 3) == 0));
        end
        cycle(1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0);
        cycle(1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule